// File: doc/BRIEF.md
# Modem Command Script Sequencer and Payload Streamer

This block brings up a serial Wi-Fi modem by sending it a fixed series of text commands, then turns into a raw data pump. The commands are built into the logic as ASCII character codes. They are handed one byte at a time to a byte-wide UART transmitter over a valid/ready handshake. Each command ends with a carriage return and a line feed, and a programmable quiet period follows every line feed. That period gives the modem time to act on the command, because the block does not read any reply.

The script puts the modem into transparent mode and opens a transmit session. After that the block waits until a capture buffer holds a complete payload set, written through a separate port with its own enable. It then sends the set byte for byte with nothing added. When the set has gone out, the buffer is empty again and the block waits for the next full set. The script is not replayed. The UART that follows this block must run at 115200 baud to match the modem. Choosing that baud rate is the transmitter's job and is not part of this block.

States: `ST_SEND_CMD` offers script bytes, `ST_CMD_GAP` holds the quiet period, `ST_AWAIT_FILL` waits for a full payload set, and `ST_STREAM` offers payload bytes. Transitions:
- send-to-gap: a line feed is accepted.
- gap-to-send: the timer expires with script bytes left.
- gap-to-stream: the timer expires after the last command and the buffer is full.
- gap-to-await: the timer expires after the last command and the buffer is not full.
- await-to-stream: the buffer becomes full.
- stream-to-await: the final payload byte is accepted.

Reset enters `ST_SEND_CMD` at script index 0.

Top module: `modem_script_streamer`

## Requirements
- R1: Reset behaviour. After reset, `tx_valid` is high, `tx_byte` is 0x41 (the first script character), and both `script_done` and `stream_done` are low.
- R2: Script content and order. The script is 85 bytes in total, sent as these five commands in order, each followed by 0x0D then 0x0A:
  - `AT+RST`
  - `AT+CWMODE=3`
  - `AT+CIPSTART="TCP","192.168.4.2",8084`
  - `AT+CIPMODE=1`
  - `AT+CIPSEND`
- R3: Handshake. A byte is consumed only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_byte` holds its value, so no byte is lost or repeated.
- R4: Quiet period. After each script line feed other than the last, `tx_valid` is low for exactly `GAP_CYCLES` cycles, and then the next command's first byte is offered.
- R5: `script_done` is high for exactly one cycle, the cycle in which the final script byte (the last 0x0A) is accepted. It fires once per reset.
- R6: Streaming does not begin until `PAYLOAD_LEN` bytes have been captured. With fewer bytes captured, `tx_valid` stays low once the script is finished.
- R7: The payload goes out as exactly `PAYLOAD_LEN` bytes, in the order they were written, with no bytes added.
- R8: `stream_done` is high for exactly one cycle, the cycle in which the final payload byte is accepted.
- R9: Writes made while the buffer already holds `PAYLOAD_LEN` bytes are ignored and do not change the payload that is sent.
- R10: After a payload set has been sent, the buffer is empty. A new full set is streamed in the same way, and no script byte is sent again.
- R11: A reset in the middle of the script starts the sequence again from the first character of the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_wr_en | input | 1 | Payload write enable |
| cap_wr_data | input | 8 | Payload write byte |
| tx_ready | input | 1 | UART transmitter can accept a byte |
| tx_valid | output | 1 | A byte is offered on `tx_byte` |
| tx_byte | output | 8 | Byte offered to the UART |
| script_done | output | 1 | One-cycle pulse when the last script byte is accepted |
| stream_done | output | 1 | One-cycle pulse when the last payload byte is accepted |

## Verification
The hardest case to reach from the ports is a line-feed byte in the middle of the payload. In `ST_STREAM` such a byte must not open a quiet period, and the only difference from a script line feed is which phase the block is in. The bench generates payload values that include 0x0A and runs under stalling ready patterns that hold bytes across many cycles. A second payload set is written only after `stream_done`, which drives the buffer back through the refill path. The bench also stops one byte short of a full set, so the block must sit waiting after the script has ended.

// File: rtl/mss_pkg.sv
package mss_pkg;

    typedef enum logic [1:0] {
        ST_SEND_CMD,
        ST_CMD_GAP,
        ST_AWAIT_FILL,
        ST_STREAM
    } seq_state_e;

    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;

    localparam int MAX_CMD = 38;

    localparam int LEN_RESTART  = 8;
    localparam int LEN_MODE     = 13;
    localparam int LEN_CONNECT  = 38;
    localparam int LEN_PASSTHRU = 14;
    localparam int LEN_SEND     = 12;

    localparam int OFS_MODE     = LEN_RESTART;
    localparam int OFS_CONNECT  = OFS_MODE + LEN_MODE;
    localparam int OFS_PASSTHRU = OFS_CONNECT + LEN_CONNECT;
    localparam int OFS_SEND     = OFS_PASSTHRU + LEN_PASSTHRU;
    localparam int SCRIPT_LEN   = OFS_SEND + LEN_SEND;
    localparam int SCRIPT_IDX_W = $clog2(SCRIPT_LEN + 1);

    // Each command right-aligned in a MAX_CMD-character field.
    localparam logic [8*MAX_CMD-1:0] CMD_RESTART =
        {{(8*(MAX_CMD-LEN_RESTART)){1'b0}}, "AT+RST", CH_CR, CH_LF};
    localparam logic [8*MAX_CMD-1:0] CMD_MODE =
        {{(8*(MAX_CMD-LEN_MODE)){1'b0}}, "AT+CWMODE=3", CH_CR, CH_LF};
    localparam logic [8*MAX_CMD-1:0] CMD_CONNECT =
        {"AT+CIPSTART=\"TCP\",\"192.168.4.2\",8084", CH_CR, CH_LF};
    localparam logic [8*MAX_CMD-1:0] CMD_PASSTHRU =
        {{(8*(MAX_CMD-LEN_PASSTHRU)){1'b0}}, "AT+CIPMODE=1", CH_CR, CH_LF};
    localparam logic [8*MAX_CMD-1:0] CMD_SEND =
        {{(8*(MAX_CMD-LEN_SEND)){1'b0}}, "AT+CIPSEND", CH_CR, CH_LF};

    // Character pos of a right-aligned command of length len.
    function automatic logic [7:0] cmd_char(input logic [8*MAX_CMD-1:0] str,
                                            input int len, input int pos);
        return str[8*(len-1-pos) +: 8];
    endfunction

    function automatic logic [7:0] script_char(input int idx);
        if (idx < OFS_MODE)
            return cmd_char(CMD_RESTART, LEN_RESTART, idx);
        else if (idx < OFS_CONNECT)
            return cmd_char(CMD_MODE, LEN_MODE, idx - OFS_MODE);
        else if (idx < OFS_PASSTHRU)
            return cmd_char(CMD_CONNECT, LEN_CONNECT, idx - OFS_CONNECT);
        else if (idx < OFS_SEND)
            return cmd_char(CMD_PASSTHRU, LEN_PASSTHRU, idx - OFS_PASSTHRU);
        else if (idx < SCRIPT_LEN)
            return cmd_char(CMD_SEND, LEN_SEND, idx - OFS_SEND);
        else
            return 8'h00;
    endfunction

endpackage

// File: rtl/mss_script_rom.sv
module mss_script_rom
    import mss_pkg::*;
(
    input  logic [SCRIPT_IDX_W-1:0] char_idx,
    output logic [7:0]              char_code,
    output logic                    final_char
);

    always_comb begin
        char_code  = script_char(int'(char_idx));
        final_char = (int'(char_idx) == SCRIPT_LEN - 1);
    end

endmodule

// File: rtl/mss_gap_timer.sv
module mss_gap_timer #(
    parameter int unsigned GAP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (cnt_q != CNT_LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == CNT_LAST);

endmodule

// File: rtl/mss_payload_buf.sv
module mss_payload_buf #(
    parameter int DEPTH = 4094
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [7:0]               wr_data,
    input  logic                     clear,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic                     full,
    output logic [7:0]               rd_data
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] fill_q;
    logic          take;

    assign full = (fill_q == CW'(DEPTH));
    assign take = wr_en && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fill_q <= '0;
        else if (clear)
            fill_q <= '0;
        else if (take)
            fill_q <= fill_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (take)
            mem[fill_q[AW-1:0]] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/modem_script_streamer.sv
module modem_script_streamer
    import mss_pkg::*;
#(
    parameter int unsigned GAP_CYCLES  = 2000000,
    parameter int          PAYLOAD_LEN = 4094
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_wr_en,
    input  logic [7:0] cap_wr_data,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       script_done,
    output logic       stream_done
);

    localparam int BUF_AW = $clog2(PAYLOAD_LEN);
    localparam logic [BUF_AW-1:0]       RD_LAST    = BUF_AW'(PAYLOAD_LEN - 1);
    localparam logic [SCRIPT_IDX_W-1:0] SCRIPT_END = SCRIPT_IDX_W'(SCRIPT_LEN);

    seq_state_e state_q, state_d;

    logic [SCRIPT_IDX_W-1:0] cmd_idx_q;
    logic [BUF_AW-1:0]       rd_idx_q;

    logic [7:0] rom_char;
    logic       rom_final;
    logic       gap_expire;
    logic       buf_full;
    logic [7:0] buf_rd;

    logic cmd_take;
    logic pay_take;
    logic pay_final;
    logic buf_clear;
    logic script_finished;

    mss_script_rom u_rom (
        .char_idx   (cmd_idx_q),
        .char_code  (rom_char),
        .final_char (rom_final)
    );

    mss_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_CMD_GAP),
        .expire (gap_expire)
    );

    mss_payload_buf #(.DEPTH(PAYLOAD_LEN)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cap_wr_en),
        .wr_data (cap_wr_data),
        .clear   (buf_clear),
        .rd_idx  (rd_idx_q),
        .full    (buf_full),
        .rd_data (buf_rd)
    );

    assign pay_final       = (rd_idx_q == RD_LAST);
    assign script_finished = (cmd_idx_q == SCRIPT_END);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_SEND_CMD;
        else
            state_q <= state_d;
    end

    // Script and payload positions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_idx_q <= '0;
            rd_idx_q  <= '0;
        end else begin
            if (cmd_take)
                cmd_idx_q <= cmd_idx_q + 1'b1;
            if (pay_take)
                rd_idx_q <= pay_final ? '0 : rd_idx_q + 1'b1;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEND_CMD: begin
                if (tx_ready && rom_char == CH_LF)
                    state_d = ST_CMD_GAP;
            end
            ST_CMD_GAP: begin
                if (gap_expire) begin
                    if (!script_finished)
                        state_d = ST_SEND_CMD;
                    else if (buf_full)
                        state_d = ST_STREAM;
                    else
                        state_d = ST_AWAIT_FILL;
                end
            end
            ST_AWAIT_FILL: begin
                if (buf_full)
                    state_d = ST_STREAM;
            end
            ST_STREAM: begin
                if (tx_ready && pay_final)
                    state_d = ST_AWAIT_FILL;
            end
        endcase
    end

    // Outputs
    always_comb begin
        tx_valid    = 1'b0;
        tx_byte     = 8'h00;
        cmd_take    = 1'b0;
        pay_take    = 1'b0;
        script_done = 1'b0;
        stream_done = 1'b0;
        buf_clear   = 1'b0;
        unique case (state_q)
            ST_SEND_CMD: begin
                tx_valid    = 1'b1;
                tx_byte     = rom_char;
                cmd_take    = tx_ready;
                script_done = tx_ready && rom_final;
            end
            ST_CMD_GAP, ST_AWAIT_FILL: begin
                tx_valid = 1'b0;
            end
            ST_STREAM: begin
                tx_valid    = 1'b1;
                tx_byte     = buf_rd;
                pay_take    = tx_ready;
                stream_done = tx_ready && pay_final;
                buf_clear   = tx_ready && pay_final;
            end
        endcase
    end

endmodule

// File: rtl/mss_checker.sv
module mss_checker #(
    parameter int unsigned GAP_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_byte,
    input logic       script_done,
    input logic       stream_done
);

    logic        in_script;
    logic        sd_seen;
    logic        in_gap;
    int unsigned gap_cnt;
    logic        lf_take;

    assign lf_take = tx_valid && tx_ready && (tx_byte == 8'h0A) && in_script && !script_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_script <= 1'b1;
            sd_seen   <= 1'b0;
            in_gap    <= 1'b0;
            gap_cnt   <= 0;
        end else begin
            if (script_done) begin
                in_script <= 1'b0;
                sd_seen   <= 1'b1;
            end
            if (lf_take) begin
                in_gap  <= 1'b1;
                gap_cnt <= 0;
            end else if (in_gap) begin
                if (tx_valid)
                    in_gap <= 1'b0;
                else
                    gap_cnt <= gap_cnt + 1;
            end
        end
    end

    // R3
    held_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

    // R4
    gap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lf_take |=> !tx_valid);

    // R4
    gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap && tx_valid |-> gap_cnt == GAP_CYCLES);

    // R5
    script_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        script_done |-> tx_valid && tx_ready && tx_byte == 8'h0A);

    // R5
    script_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        script_done |-> !sd_seen);

    // R8
    stream_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stream_done |-> tx_valid && tx_ready && sd_seen && !script_done);

endmodule

bind modem_script_streamer mss_checker #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_byte     (tx_byte),
    .script_done (script_done),
    .stream_done (stream_done)
);

// File: tb/tb_modem_script_streamer.sv
module tb_modem_script_streamer;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 5;
    localparam int LEN        = 16;
    localparam int SLEN       = 85;
    localparam int NV         = 4;
    // vector table: ready pattern (0 always, 1 random, 2 one in three) and payload seed
    localparam int V_MODE [NV] = '{0, 1, 2, 1};
    localparam int V_SEED [NV] = '{8'h10, 8'h5A, 8'hC3, 8'h07};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_wr_en = 1'b0;
    logic [7:0] cap_wr_data = 8'h00;
    logic       tx_ready = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       script_done;
    logic       stream_done;

    modem_script_streamer #(.GAP_CYCLES(GAP), .PAYLOAD_LEN(LEN)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_wr_en   (cap_wr_en),
        .cap_wr_data (cap_wr_data),
        .tx_ready    (tx_ready),
        .tx_valid    (tx_valid),
        .tx_byte     (tx_byte),
        .script_done (script_done),
        .stream_done (stream_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] exp_s [SLEN];
    int         exp_n = 0;
    logic [7:0] rec [1024];
    int         rec_n;
    int         sd_cnt, sd_pos, sdn_cnt;
    int         sdn_pos [8];
    logic [7:0] wbuf [128];
    int         w_pos, w_end;
    logic [15:0] lfsr;
    int         cyc;
    bit         in_gap, prev_stall;
    int         gap_len;
    logic [7:0] prev_byte;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] pay(input int seed, input int k);
        return 8'(seed + k * 37 + (k >> 2));
    endfunction

    task automatic add_cmd(input string s);
        for (int i = 0; i < s.len(); i++) begin
            exp_s[exp_n] = s[i];
            exp_n++;
        end
        exp_s[exp_n] = 8'h0D; exp_n++;
        exp_s[exp_n] = 8'h0A; exp_n++;
    endtask

    task automatic load_payload(input int seed, input int n);
        for (int k = 0; k < n; k++) begin
            wbuf[w_end] = pay(seed, k);
            w_end++;
        end
    endtask

    task automatic reset_dut(input string tag);
        rst_n = 1'b0; cap_wr_en = 1'b0; tx_ready = 1'b0;
        rec_n = 0; sd_cnt = 0; sd_pos = -1; sdn_cnt = 0;
        w_pos = 0; w_end = 0; cyc = 0;
        in_gap = 0; prev_stall = 0; gap_len = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(tx_valid == 1'b1, tag, "valid after reset", tx_valid, 1);
        check(tx_byte == 8'h41, tag, "first byte after reset", tx_byte, 8'h41);
        check(!script_done && !stream_done, tag, "done pulses after reset",
              {script_done, stream_done}, 0);
    endtask

    task automatic step(input int mode);
        @(negedge clk);
        cyc++;
        case (mode)
            0: tx_ready = 1'b1;
            1: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tx_ready = lfsr[0] | lfsr[5];
            end
            default: tx_ready = (cyc % 3 == 0);
        endcase
        if (w_pos < w_end) begin
            cap_wr_en = 1'b1; cap_wr_data = wbuf[w_pos]; w_pos++;
        end else begin
            cap_wr_en = 1'b0;
        end
        #1;
        if (prev_stall)
            check(tx_valid && tx_byte == prev_byte, "R3", "byte held under stall",
                  tx_byte, prev_byte);
        if (in_gap) begin
            if (!tx_valid) gap_len++;
            else begin
                check(gap_len == GAP, "R4", "quiet period length", gap_len, GAP);
                in_gap = 0;
            end
        end
        if (tx_valid && tx_ready) begin
            if (rec_n < 1024) rec[rec_n] = tx_byte;
            if (rec_n < SLEN - 1 && tx_byte == 8'h0A) begin
                in_gap = 1; gap_len = 0;
            end
            if (script_done) begin sd_pos = rec_n; sd_cnt++; end
            if (stream_done) begin
                if (sdn_cnt < 8) sdn_pos[sdn_cnt] = rec_n;
                sdn_cnt++;
            end
            rec_n++;
        end else begin
            if (script_done) check(0, "R5", "script_done without transfer", 1, 0);
            if (stream_done) check(0, "R8", "stream_done without transfer", 1, 0);
        end
        prev_stall = tx_valid && !tx_ready;
        prev_byte  = tx_byte;
    endtask

    task automatic run_until_streams(input int mode, input int target);
        for (int i = 0; i < 5000 && sdn_cnt < target; i++) step(mode);
    endtask

    task automatic check_script(input string tag);
        for (int i = 0; i < SLEN; i++)
            check(rec[i] == exp_s[i], tag, $sformatf("script byte %0d", i), rec[i], exp_s[i]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        add_cmd("AT+RST");
        add_cmd("AT+CWMODE=3");
        add_cmd("AT+CIPSTART=\"TCP\",\"192.168.4.2\",8084");
        add_cmd("AT+CIPMODE=1");
        add_cmd("AT+CIPSEND");

        // vector walk: R2 R4 R5 R7 R8 R9 R10 under each ready pattern
        for (int v = 0; v < NV; v++) begin
            reset_dut("R1");
            lfsr = 16'hACE1 ^ 16'(V_SEED[v]);
            load_payload(V_SEED[v], LEN);
            for (int k = 0; k < 6; k++) begin
                wbuf[w_end] = 8'hEE ^ 8'(k); w_end++;
            end
            run_until_streams(V_MODE[v], 1);
            load_payload(V_SEED[v] + 101, LEN);
            run_until_streams(V_MODE[v], 2);
            repeat (20) step(V_MODE[v]);
            check_script("R2");
            for (int k = 0; k < LEN; k++)
                check(rec[SLEN + k] == pay(V_SEED[v], k), "R7 R9",
                      $sformatf("payload byte %0d", k), rec[SLEN + k], pay(V_SEED[v], k));
            for (int k = 0; k < LEN; k++)
                check(rec[SLEN + LEN + k] == pay(V_SEED[v] + 101, k), "R10",
                      $sformatf("second set byte %0d", k), rec[SLEN + LEN + k],
                      pay(V_SEED[v] + 101, k));
            check(rec_n == SLEN + 2 * LEN, "R10", "total bytes sent", rec_n, SLEN + 2 * LEN);
            check(sd_cnt == 1 && sd_pos == SLEN - 1, "R5", "script_done position", sd_pos, SLEN - 1);
            check(sdn_cnt == 2, "R8", "stream_done count", sdn_cnt, 2);
            check(sdn_pos[0] == SLEN + LEN - 1, "R8", "first stream_done position",
                  sdn_pos[0], SLEN + LEN - 1);
            check(sdn_pos[1] == SLEN + 2 * LEN - 1, "R8", "second stream_done position",
                  sdn_pos[1], SLEN + 2 * LEN - 1);
        end

        // R6: one byte short of a full set
        reset_dut("R1");
        load_payload(8'h33, LEN - 1);
        repeat (300) step(0);
        check(rec_n == SLEN, "R6", "bytes sent with short buffer", rec_n, SLEN);
        check(!tx_valid, "R6", "valid while waiting for fill", tx_valid, 0);
        wbuf[w_end] = pay(8'h33, LEN - 1); w_end++;
        run_until_streams(0, 1);
        for (int k = 0; k < LEN; k++)
            check(rec[SLEN + k] == pay(8'h33, k), "R6",
                  $sformatf("payload after fill byte %0d", k), rec[SLEN + k], pay(8'h33, k));

        // R11: reset in the middle of the script
        reset_dut("R1");
        repeat (40) step(0);
        check(rec_n > 8 && rec_n < SLEN, "R11", "mid-script before reset", rec_n, 30);
        reset_dut("R11");
        load_payload(8'h71, LEN);
        run_until_streams(0, 1);
        check_script("R11");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule